// File: doc/BRIEF.md
# Configurable Serial Word Transmitter

This block sends data words one bit per clock on a single serial line. Software loads a 16-bit word into a one-entry holding buffer. A configuration write sets the number of bits sent from each word (3 to 16), the bit order, where the frame sync comes from (internal or external) and whether every word needs its own sync. The block moves the buffered word into a shift register when a word may begin, and it sends only the low bits that the length selects.

The internal frame sync comes from a down-counting divider that software programs on its own. Its pulse rate therefore does not depend on the word length. The block drives the internal pulse out on a pin. The data line changes on the rising clock edge. It stays low whenever no word is being sent. The block reports whether the holding buffer can accept a word, and it keeps two sticky flags: one for a start with nothing to send and one for an illegal length setting.

Top module: `sertx`

## Requirements
- R1: The configuration write field at bits 8:5 (value L) selects L+1 bits per word. The value in force when a word begins governs that whole word.
- R2: Configuration bit 4 selects the bit order: 0 sends the most significant selected bit first, 1 sends bit 0 first.
- R3: A written length field of 0 or 1 is used as 2 (3-bit words) and sets `cfg_err`. The flag stays high until reset. Legal values 2 to 15 leave the flag unchanged.
- R4: Only bits L..0 of the loaded word reach the line. In MSB-first mode bit L is sent first, and bits above L are never sent.
- R5: The first bit of a word is on `sdo` in the cycle after the edge that samples the frame sync high. A sync that arrives while a word is still shifting, and before its last bit, has no effect.
- R6: Configuration bit 9 set selects the internal sync. `fs_out` then pulses for one cycle every D+1 cycles, where D is the value last written through `div_wr`, whatever the word length. With bit 9 clear, `fs_out` stays low and `fs_in` is used.
- R7: With configuration bit 10 set, each word needs a sync. If no sync comes at the last bit of a word, the line goes low and the block waits.
- R8: With configuration bit 10 clear, one sync starts the stream. Each further buffered word begins in the cycle right after the last bit of the previous word.
- R9: `tx_ready` is high when the holding buffer is empty. A write makes it low from the next cycle. If a write lands on the same edge that moves the buffered word into the shifter, the new word stays buffered and `tx_ready` stays low.
- R10: If a word must begin and the buffer is empty, `underflow` is set and held until reset, and `sdo` is driven low.
- R11: After reset `sdo`, `fs_out`, `underflow` and `cfg_err` are low and `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; data changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word (bits 4, 8:5, 9, 10 used) |
| div_wr | input | 1 | Frame sync divider write strobe |
| div_wdata | input | DIV_W | Divider value D (period D+1 cycles) |
| tx_wr | input | 1 | Transmit word write strobe |
| tx_wdata | input | 16 | Transmit word |
| fs_in | input | 1 | External frame sync |
| sdo | output | 1 | Serial data |
| fs_out | output | 1 | Internal frame sync pulse |
| tx_ready | output | 1 | Holding buffer empty |
| underflow | output | 1 | Sticky: a word had to begin with the buffer empty |
| cfg_err | output | 1 | Sticky: an illegal length was written |

## Verification
A host write into the holding buffer can land on the same edge that moves the buffered word into the shifter. The bench provokes this by raising `tx_wr` together with the external sync while a word is already buffered. It then judges that the first word shifts out intact, that `tx_ready` stays low, and that the second word later shifts out unchanged after its own sync. The bench also lets a continuous stream run dry, so that a required start and an empty buffer fall in the same cycle. It expects `underflow` to rise and the line to drop low right after the last expected bit.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
   // field positions that software relies on
   localparam int ORD_BIT  = 4;
   localparam int LEN_LSB  = 5;
   localparam int LEN_W    = 4;
   localparam int ITFS_BIT = 9;
   localparam int REQ_BIT  = 10;
   localparam int LEN_MIN  = 2;

   typedef struct packed {
      logic             lsb_first;
      logic [LEN_W-1:0] last_idx;
      logic             int_fs;
      logic             fs_each;
   } tx_cfg_t;
endpackage

// File: rtl/sertx_cfg.sv
module sertx_cfg
   import sertx_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output tx_cfg_t           cfg,
   output logic              err
);
   localparam logic [LEN_W-1:0] LEN_FLOOR = LEN_W'(LEN_MIN);

   logic [LEN_W-1:0] fld;
   logic             bad;
   logic             unused_cfg_bits;

   assign fld = wdata[LEN_LSB +: LEN_W];
   assign bad = (fld < LEN_FLOOR);
   assign unused_cfg_bits = ^{wdata[DATA_W-1:REQ_BIT+1], wdata[ORD_BIT-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '{lsb_first: 1'b0, last_idx: LEN_FLOOR, int_fs: 1'b0, fs_each: 1'b0};
         err <= 1'b0;
      end else if (wr) begin
         cfg.lsb_first <= wdata[ORD_BIT];
         cfg.last_idx  <= bad ? LEN_FLOOR : fld;
         cfg.int_fs    <= wdata[ITFS_BIT];
         cfg.fs_each   <= wdata[REQ_BIT];
         if (bad) err <= 1'b1;
      end
   end
endmodule

// File: rtl/sertx_fsgen.sv
module sertx_fsgen #(
   parameter int DIV_W   = 8,
   parameter int DIV_RST = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             div_wr,
   input  logic [DIV_W-1:0] div_wdata,
   input  logic             enable,
   output logic             pulse
);
   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= DIV_W'(DIV_RST);
         cnt_q <= DIV_W'(DIV_RST);
      end else if (div_wr) begin
         div_q <= div_wdata;
         cnt_q <= div_wdata;
      end else if (cnt_q == '0) begin
         cnt_q <= div_q;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign pulse = enable && (cnt_q == '0);
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
      end else if (wr) begin
         full <= 1'b1;
         data <= wdata;
      end else if (take) begin
         full <= 1'b0;
      end
   end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
   import sertx_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tx_cfg_t           cfg,
   input  logic              fs,
   input  logic              buf_full,
   input  logic [DATA_W-1:0] buf_data,
   output logic              take,
   output logic              sdo,
   output logic              busy,
   output logic              underflow
);
   logic [DATA_W-1:0] norm;
   logic [DATA_W-1:0] sh_q;
   logic [LEN_W-1:0]  cnt_q;
   logic              last_bit;
   logic              start_req;
   logic              start_fail;

   // put the selected bits in send order, bit 0 leaves first
   for (genvar i = 0; i < DATA_W; i++) begin : g_norm
      logic [LEN_W-1:0] ridx;
      assign ridx    = cfg.last_idx - LEN_W'(i);
      assign norm[i] = (LEN_W'(i) <= cfg.last_idx) ?
                       (cfg.lsb_first ? buf_data[i] : buf_data[ridx]) : 1'b0;
   end

   assign last_bit   = busy && (cnt_q == '0);
   assign start_req  = (!busy && fs) || (last_bit && (cfg.fs_each ? fs : 1'b1));
   assign take       = start_req && buf_full;
   assign start_fail = start_req && !buf_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q      <= '0;
         cnt_q     <= '0;
         sdo       <= 1'b0;
         busy      <= 1'b0;
         underflow <= 1'b0;
      end else if (take) begin
         sh_q  <= norm >> 1;
         sdo   <= norm[0];
         cnt_q <= cfg.last_idx;
         busy  <= 1'b1;
      end else if (start_fail) begin
         sdo       <= 1'b0;
         busy      <= 1'b0;
         underflow <= 1'b1;
      end else if (busy && cnt_q != '0) begin
         sdo   <= sh_q[0];
         sh_q  <= sh_q >> 1;
         cnt_q <= cnt_q - 1'b1;
      end else if (busy) begin
         sdo  <= 1'b0;
         busy <= 1'b0;
      end
   end
endmodule

// File: rtl/sertx.sv
module sertx
   import sertx_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int DIV_W   = 8,
   parameter int DIV_RST = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              div_wr,
   input  logic [DIV_W-1:0]  div_wdata,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_wdata,
   input  logic              fs_in,
   output logic              sdo,
   output logic              fs_out,
   output logic              tx_ready,
   output logic              underflow,
   output logic              cfg_err
);
   if (DATA_W != (1 << LEN_W)) begin : g_bad_width
      $error("sertx: DATA_W must equal 2**LEN_W");
   end
   if (DIV_W < 1 || DIV_RST < 0 || DIV_RST >= (1 << DIV_W)) begin : g_bad_div
      $error("sertx: DIV_RST must fit in DIV_W bits");
   end

   tx_cfg_t           cfg_q;
   logic              int_sel;
   logic              fs_int;
   logic              fs_sel;
   logic              buf_full;
   logic [DATA_W-1:0] buf_data;
   logic              take;
   logic              shift_busy;

   sertx_cfg #(.DATA_W(DATA_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
      .cfg(cfg_q), .err(cfg_err)
   );

   assign int_sel = cfg_q.int_fs;

   sertx_fsgen #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_fsgen (
      .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
      .enable(int_sel), .pulse(fs_int)
   );

   assign fs_sel = int_sel ? fs_int : fs_in;
   assign fs_out = fs_int;

   sertx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .wr(tx_wr), .wdata(tx_wdata),
      .take(take), .full(buf_full), .data(buf_data)
   );

   assign tx_ready = !buf_full;

   sertx_shift #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .fs(fs_sel),
      .buf_full(buf_full), .buf_data(buf_data), .take(take),
      .sdo(sdo), .busy(shift_busy), .underflow(underflow)
   );
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_wr,
   input logic tx_ready,
   input logic underflow,
   input logic cfg_err,
   input logic sdo,
   input logic busy,
   input logic fs_out,
   input logic int_sel,
   input logic fs_sel
);
   // R10
   underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> underflow);

   // R3
   cfg_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);

   // R9
   ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_wr |=> !tx_ready);

   // R6
   ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !int_sel |-> !fs_out);

   // R7
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sdo);

   // R5
   start_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(fs_sel));
endmodule

bind sertx sertx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_ready(tx_ready),
   .underflow(underflow), .cfg_err(cfg_err), .sdo(sdo), .busy(shift_busy),
   .fs_out(fs_out), .int_sel(int_sel), .fs_sel(fs_sel)
);

// File: tb/tb_sertx.sv
module tb_sertx;
   localparam int DW = 16;
   localparam int DV = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [DW-1:0] cfg_wdata = '0;
   logic          div_wr = 1'b0;
   logic [DV-1:0] div_wdata = '0;
   logic          tx_wr = 1'b0;
   logic [DW-1:0] tx_wdata = '0;
   logic          fs_in = 1'b0;
   logic          sdo, fs_out, tx_ready, underflow, cfg_err;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic exp_q[$];
   string bit_tag = "R4";

   sertx #(.DATA_W(DW), .DIV_W(DV), .DIV_RST(15)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .div_wr(div_wr), .div_wdata(div_wdata), .tx_wr(tx_wr),
      .tx_wdata(tx_wdata), .fs_in(fs_in), .sdo(sdo), .fs_out(fs_out),
      .tx_ready(tx_ready), .underflow(underflow), .cfg_err(cfg_err)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // monitor: one expected bit per cycle after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (exp_q.size() != 0) begin
            logic e;
            e = exp_q.pop_front();
            check(sdo === e, bit_tag, int'(sdo), int'(e));
         end
      end
   end

   // driver helpers
   task automatic push_word(input logic [DW-1:0] w, input int last, input logic lsb);
      for (int i = 0; i <= last; i++) exp_q.push_back(lsb ? w[i] : w[last-i]);
   endtask

   task automatic cfg_write(input logic [DW-1:0] v);
      @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   task automatic tx_write(input logic [DW-1:0] v);
      @(negedge clk); tx_wr = 1'b1; tx_wdata = v;
      @(negedge clk); tx_wr = 1'b0;
   endtask

   task automatic start_ext(input logic [DW-1:0] w, input int last, input logic lsb);
      @(negedge clk); fs_in = 1'b1; push_word(w, last, lsb);
      @(negedge clk); fs_in = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int fs_t[3];
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check(sdo == 1'b0, "R11 sdo", int'(sdo), 0);
      check(tx_ready == 1'b1, "R11 tx_ready", int'(tx_ready), 1);
      check(underflow == 1'b0, "R11 underflow", int'(underflow), 0);
      check(cfg_err == 1'b0, "R11 cfg_err", int'(cfg_err), 0);
      check(fs_out == 1'b0, "R6 R11 fs_out external", int'(fs_out), 0);

      // R1 R2 8-bit LSB-first, sync per word, external sync
      cfg_write(16'h04F0);
      check(cfg_err == 1'b0, "R3 legal length", int'(cfg_err), 0);
      tx_write(16'hA5C3);
      check(tx_ready == 1'b0, "R9 ready after write", int'(tx_ready), 0);
      bit_tag = "R2 lsb-first";
      start_ext(16'hA5C3, 7, 1'b1);
      check(tx_ready == 1'b1, "R9 ready after load", int'(tx_ready), 1);
      drain();
      check(sdo == 1'b0, "R7 line low w/o sync", int'(sdo), 0);
      check(underflow == 1'b0, "R7 no underflow w/o sync", int'(underflow), 0);

      // R4 R5 12-bit MSB-first, mid-word sync ignored
      cfg_write(16'h0560);
      tx_write(16'hF123);
      bit_tag = "R4 msb-first low bits";
      start_ext(16'hF123, 11, 1'b0);
      repeat (3) @(negedge clk);
      fs_in = 1'b1;
      @(negedge clk); fs_in = 1'b0;
      drain();
      check(sdo == 1'b0, "R5 mid-word sync ignored", int'(sdo), 0);

      // R3 illegal length 1 treated as 3-bit word
      cfg_write(16'h0430);
      check(cfg_err == 1'b1, "R3 cfg_err set", int'(cfg_err), 1);
      tx_write(16'hFFF6);
      bit_tag = "R3 clamped length";
      start_ext(16'hFFF6, 2, 1'b1);
      drain();
      cfg_write(16'h04E0);
      check(cfg_err == 1'b1, "R3 cfg_err sticky", int'(cfg_err), 1);

      // R9 write lands on the load edge
      tx_write(16'h00AA);
      @(negedge clk);
      fs_in = 1'b1; tx_wr = 1'b1; tx_wdata = 16'h0055;
      bit_tag = "R9 first word";
      push_word(16'h00AA, 7, 1'b0);
      @(negedge clk);
      fs_in = 1'b0; tx_wr = 1'b0;
      check(tx_ready == 1'b0, "R9 same-edge write kept", int'(tx_ready), 0);
      drain();
      check(tx_ready == 1'b0, "R9 still buffered", int'(tx_ready), 0);
      bit_tag = "R9 second word";
      start_ext(16'h0055, 7, 1'b0);
      drain();
      check(tx_ready == 1'b1, "R9 drained", int'(tx_ready), 1);

      // R8 R10 continuous 5-bit stream running dry
      cfg_write(16'h0090);
      tx_write(16'h0013);
      bit_tag = "R8 back-to-back";
      start_ext(16'h0013, 4, 1'b1);
      push_word(16'h001C, 4, 1'b1);
      tx_write(16'h001C);
      drain();
      check(underflow == 1'b1, "R10 underflow set", int'(underflow), 1);
      check(sdo == 1'b0, "R10 line low", int'(sdo), 0);
      repeat (3) @(negedge clk);
      check(underflow == 1'b1, "R10 underflow sticky", int'(underflow), 1);

      // R6 internal sync period independent of length
      cfg_write(16'h0650);
      @(negedge clk); div_wr = 1'b1; div_wdata = 8'd5;
      @(negedge clk); div_wr = 1'b0;
      n = 0;
      for (int k = 0; k < 40 && n < 3; k++) begin
         @(negedge clk);
         if (fs_out) begin fs_t[n] = cyc; n++; end
      end
      check(n == 3, "R6 pulses seen", n, 3);
      check(fs_t[1] - fs_t[0] == 6, "R6 period", fs_t[1] - fs_t[0], 6);
      check(fs_t[2] - fs_t[1] == 6, "R6 period", fs_t[2] - fs_t[1], 6);
      tx_write(16'h0005);
      do @(negedge clk); while (!fs_out);
      bit_tag = "R6 internal start";
      push_word(16'h0005, 2, 1'b1);
      drain();
      check(tx_ready == 1'b1, "R6 word consumed", int'(tx_ready), 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule